// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between a set of free-running clock sources and the pads that carry them off chip. One source is the processor clock, which also clocks the control logic. The others are peripheral clocks of unrelated phase. Each output can be switched on or off by its own enable bit. An active-low power-down pin stops every output. Outputs always stop low and always restart on a rising edge, so no shortened pulse ever reaches a pad.

A power-down request passes through a synchroniser in the processor clock domain. It is acted on only after two consecutive processor-clock samples show it low. The controller then withdraws the run permission from every output and waits until each output has parked low. Only then does it raise a request that stops the oscillator and the PLLs. When the pin returns high, the stop request drops at once. The outputs then stay low for a programmable settle count, after which they are released. The same settle count runs after reset, before the first release. A separate tristate request turns the pad drivers off and forces every output low, whatever the gating state.

Top module: `clk_gate_ctrl`

## Requirements
- R1: While reset is asserted, every clock output is low, `osc_stop` is low and `pad_oe` is high.
- R2: After reset is released, no output toggles for at least `SETTLE_CYC` processor clock cycles. After that, each enabled output follows its source clock.
- R3: Every high pulse on an output lasts exactly the full high phase of its source clock: there are no runt pulses at any start or stop.
- R4: Bit 0 of `clk_en` controls `cpu_clk_out` and bit i+1 controls `per_clk_out[i]`. A set bit makes the output follow its source. A cleared bit holds the output low.
- R5: A low level on `pwrdn_n` that is seen on only one processor-clock rising edge has no effect: `osc_stop` stays low and the outputs keep running.
- R6: A low level on `pwrdn_n` seen on two consecutive processor-clock rising edges parks all outputs low and then raises `osc_stop`.
- R7: `osc_stop` is high only while every output gate is closed.
- R8: While power-down is in effect, changing `clk_en` has no effect: all outputs stay low.
- R9: When `pwrdn_n` returns high, `osc_stop` falls. The outputs stay low for at least `SETTLE_CYC` processor cycles and then follow their sources again.
- R10: While `tristate_req` is high, `pad_oe` is low and every clock output is low. When it is cleared, the gated outputs return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu | input | 1 | Processor clock source; also clocks the control logic |
| clk_per | input | N_PER | Peripheral clock sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down request pin |
| clk_en | input | N_PER+1 | Per-output enables: bit 0 for the processor clock, bit i+1 for peripheral i |
| tristate_req | input | 1 | Turns the pad drivers off and forces the outputs low |
| cpu_clk_out | output | 1 | Gated processor clock |
| per_clk_out | output | N_PER | Gated peripheral clocks |
| pad_oe | output | 1 | Pad output enable, active high |
| osc_stop | output | 1 | Request to stop the oscillator and PLLs |

## Verification
The bench builds the block with three peripheral clocks, so there are four gated outputs, and with `SETTLE_CYC` set to 16. With four outputs, all sixteen enable patterns can be swept, and every output is checked in both states under each pattern. The short settle count makes both the reset-release delay and the wake-up delay measurable in processor cycles against a tight window. The peripheral periods are 30, 40 and 60 ns against a 20 ns processor period. This keeps the stop and restart points landing at varied phases, and every output pulse on every source is width-checked for runts.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  typedef enum logic [1:0] {
    PD_WAKE = 2'd0,
    PD_RUN  = 2'd1,
    PD_PARK = 2'd2,
    PD_OFF  = 2'd3
  } pd_state_t;
endpackage

// File: rtl/cgc_sync.sv
module cgc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else begin
      sh[0] <= d;
      for (int s = 1; s < STAGES; s++) sh[s] <= sh[s-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cgc_gate_cell.sv
// One glitch-free gate: the permission is synchronised into the source
// domain and sampled on the falling edge, while the source is low.
module cgc_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic run_req,
  output logic clk_gated,
  output logic gate_on
);
  logic rst_loc_n;
  logic run_s;
  logic gate_q, gate_d;

  cgc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_rst (
    .clk(clk_src), .rst_n(rst_n), .d(1'b1), .q(rst_loc_n)
  );

  cgc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_run (
    .clk(clk_src), .rst_n(rst_loc_n), .d(run_req), .q(run_s)
  );

  always_comb gate_d = run_s;

  always_ff @(negedge clk_src or negedge rst_loc_n) begin
    if (!rst_loc_n) gate_q <= 1'b0;
    else            gate_q <= gate_d;
  end

  assign clk_gated = clk_src & gate_q;
  assign gate_on   = gate_q;
endmodule

// File: rtl/cgc_pd_ctrl.sv
module cgc_pd_ctrl
  import cgc_pkg::*;
#(
  parameter int SETTLE_CYC  = 300000,
  parameter int PARK_MIN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn_n,
  input  logic parked_all,
  output logic run,
  output logic osc_stop,
  output logic req_s,
  output logic req_d
);
  localparam int CNT_MAX = (SETTLE_CYC > PARK_MIN) ? SETTLE_CYC : PARK_MIN;
  localparam int CW      = $clog2(CNT_MAX + 1);

  pd_state_t      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           pd_hit;

  cgc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_req (
    .clk(clk), .rst_n(rst_n), .d(~pwrdn_n), .q(req_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_s;
  end

  assign pd_hit = req_s & req_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PD_WAKE: begin
        if (cnt_q == CW'(SETTLE_CYC - 1)) begin
          st_d  = PD_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PD_RUN: begin
        if (pd_hit) begin
          st_d  = PD_PARK;
          cnt_d = '0;
        end
      end
      PD_PARK: begin
        if (cnt_q < CW'(PARK_MIN)) cnt_d = cnt_q + CW'(1);
        else if (parked_all)       st_d  = PD_OFF;
      end
      PD_OFF: begin
        if (!req_s) begin
          st_d  = PD_WAKE;
          cnt_d = '0;
        end
      end
      default: st_d = PD_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PD_WAKE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign run      = (st_q == PD_RUN);
  assign osc_stop = (st_q == PD_OFF);
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter int N_PER       = 3,
  parameter int SETTLE_CYC  = 300000,
  parameter int SYNC_STAGES = 2,
  parameter int PARK_MIN    = 4
) (
  input  logic             clk_cpu,
  input  logic [N_PER-1:0] clk_per,
  input  logic             rst_n,
  input  logic             pwrdn_n,
  input  logic [N_PER:0]   clk_en,
  input  logic             tristate_req,
  output logic             cpu_clk_out,
  output logic [N_PER-1:0] per_clk_out,
  output logic             pad_oe,
  output logic             osc_stop
);
  localparam int NCLK = N_PER + 1;

  logic            rst_cpu_n;
  logic            run, req_s, req_d;
  logic [NCLK-1:0] clk_src, clk_gated, gate_on, gate_on_s, run_req;
  logic            parked_all;

  cgc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_rst_cpu (
    .clk(clk_cpu), .rst_n(rst_n), .d(1'b1), .q(rst_cpu_n)
  );

  cgc_pd_ctrl #(
    .SETTLE_CYC(SETTLE_CYC), .PARK_MIN(PARK_MIN), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk_cpu), .rst_n(rst_cpu_n), .pwrdn_n(pwrdn_n),
    .parked_all(parked_all), .run(run), .osc_stop(osc_stop),
    .req_s(req_s), .req_d(req_d)
  );

  assign clk_src = {clk_per, clk_cpu};
  assign run_req = clk_en & {NCLK{run}};

  for (genvar i = 0; i < NCLK; i++) begin : g_gate
    cgc_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_src(clk_src[i]), .rst_n(rst_n), .run_req(run_req[i]),
      .clk_gated(clk_gated[i]), .gate_on(gate_on[i])
    );
  end

  cgc_sync #(.STAGES(SYNC_STAGES), .WIDTH(NCLK)) u_park_sync (
    .clk(clk_cpu), .rst_n(rst_cpu_n), .d(gate_on), .q(gate_on_s)
  );

  assign parked_all  = (gate_on_s == '0);
  assign pad_oe      = ~tristate_req;
  assign cpu_clk_out = clk_gated[0] & ~tristate_req;
  assign per_clk_out = clk_gated[NCLK-1:1] & {N_PER{~tristate_req}};
endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk #(
  parameter int NCLK = 4
) (
  input logic            clk_cpu,
  input logic            rst_n,
  input logic            osc_stop,
  input logic            pad_oe,
  input logic            tristate_req,
  input logic            cpu_clk_out,
  input logic [NCLK-2:0] per_clk_out,
  input logic [NCLK-1:0] gate_on,
  input logic            run,
  input logic            req_s,
  input logic            req_d
);
  AST_STOP_PARKED: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    osc_stop |-> (gate_on == '0)); // R7

  AST_TWO_SAMPLES: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $fell(run) |-> ($past(req_s) && $past(req_d))); // R6

  AST_TRI_QUIET: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    tristate_req |-> (!pad_oe && !cpu_clk_out && (per_clk_out == '0))); // R10

  AST_WAKE_PARKED: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $fell(osc_stop) |-> (gate_on == '0)); // R9
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(.NCLK(N_PER + 1)) u_chk (
  .clk_cpu(clk_cpu), .rst_n(rst_n), .osc_stop(osc_stop), .pad_oe(pad_oe),
  .tristate_req(tristate_req), .cpu_clk_out(cpu_clk_out),
  .per_clk_out(per_clk_out), .gate_on(gate_on), .run(run),
  .req_s(req_s), .req_d(req_d)
);

// File: tb/sim_clk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_clk_gate_ctrl;
  localparam int N_PER  = 3;
  localparam int SETTLE = 16;
  localparam int HP [4] = '{10, 15, 20, 30};

  logic             clk_cpu;
  logic [N_PER-1:0] clk_per;
  logic             rst_n, pwrdn_n, tristate_req;
  logic [N_PER:0]   clk_en;
  logic             cpu_clk_out, pad_oe, osc_stop;
  logic [N_PER-1:0] per_clk_out;
  logic [3:0]       outv, clkv;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 0;

  clk_gate_ctrl #(.N_PER(N_PER), .SETTLE_CYC(SETTLE)) u0 (
    .clk_cpu(clk_cpu), .clk_per(clk_per), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .clk_en(clk_en), .tristate_req(tristate_req), .cpu_clk_out(cpu_clk_out),
    .per_clk_out(per_clk_out), .pad_oe(pad_oe), .osc_stop(osc_stop)
  );

  assign outv = {per_clk_out, cpu_clk_out};
  assign clkv = {clk_per, clk_cpu};

  initial clk_cpu = 0;
  always #10 clk_cpu = ~clk_cpu;
  initial clk_per = '0;
  always #15 clk_per[0] = ~clk_per[0];
  always #20 clk_per[1] = ~clk_per[1];
  always #30 clk_per[2] = ~clk_per[2];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R3: each output high pulse must span the full source high phase
  for (genvar g = 0; g < 4; g++) begin : g_mon
    time t_rise = 0;
    always @(posedge outv[g]) t_rise = $time;
    always @(negedge outv[g])
      if (mon_on && t_rise != 0)
        chk(($time - t_rise) == HP[g], "R3", $sformatf("pulse width out%0d", g),
            int'($time - t_rise), HP[g]);
  end

  // Watch outputs for 400 ns at half-ns offsets from all edges
  task automatic observe(input logic [3:0] exp_run, input string req);
    logic [3:0] hi, bad;
    hi = '0; bad = '0;
    #0.5;
    repeat (400) begin
      for (int i = 0; i < 4; i++) begin
        if (exp_run[i]) begin
          if (outv[i] !== clkv[i]) bad[i] = 1'b1;
          if (outv[i]) hi[i] = 1'b1;
        end else if (outv[i] !== 1'b0) begin
          bad[i] = 1'b1;
        end
      end
      #1;
    end
    for (int i = 0; i < 4; i++)
      chk(!bad[i] && (!exp_run[i] || hi[i]), req,
          $sformatf("out%0d running(en=%h)", i, exp_run),
          int'(!bad[i] && hi[i]), int'(exp_run[i]));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    bit seen;
    rst_n = 0; pwrdn_n = 1; clk_en = 4'hF; tristate_req = 0;
    #100.5;
    chk(outv == 4'h0, "R1", "outputs in reset", outv, 0);
    chk(osc_stop == 1'b0, "R1", "osc_stop in reset", osc_stop, 0);
    chk(pad_oe == 1'b1, "R1", "pad_oe in reset", pad_oe, 1);

    // R2: delay to first release
    @(negedge clk_cpu); rst_n = 1;
    cyc = 0;
    while (!cpu_clk_out && cyc < 100) begin @(posedge clk_cpu); #1; cyc++; end
    chk(cyc >= SETTLE && cyc <= SETTLE + 8, "R2", "cycles to first release", cyc, SETTLE + 4);
    #300;
    mon_on = 1;
    observe(4'hF, "R2");

    // R4: all enable patterns
    for (int p = 0; p < 16; p++) begin
      @(negedge clk_cpu); clk_en = 4'(p);
      #300;
      observe(4'(p), "R4");
    end
    @(negedge clk_cpu); clk_en = 4'hF;
    #300;

    // R5: single-sample low pulse ignored
    @(negedge clk_cpu); pwrdn_n = 0;
    @(negedge clk_cpu); pwrdn_n = 1;
    seen = 0;
    repeat (20) begin @(posedge clk_cpu); #1; if (osc_stop) seen = 1; end
    chk(!seen, "R5", "osc_stop after one-sample pulse", seen, 0);
    observe(4'hF, "R5");

    // R6/R7: held low enters power-down
    @(negedge clk_cpu); pwrdn_n = 0;
    cyc = 0;
    while (!osc_stop && cyc < 200) begin @(posedge clk_cpu); #1; cyc++; end
    chk(osc_stop == 1'b1, "R6", "osc_stop after held low", osc_stop, 1);
    observe(4'h0, "R7");
    observe(4'h0, "R6");

    // R8: enables ignored while powered down
    @(negedge clk_cpu); clk_en = 4'h5;
    #300;
    observe(4'h0, "R8");
    chk(osc_stop == 1'b1, "R8", "osc_stop held", osc_stop, 1);
    @(negedge clk_cpu); clk_en = 4'hF;

    // R9: exit and settle
    @(negedge clk_cpu); pwrdn_n = 1;
    cyc = 0;
    while (osc_stop && cyc < 50) begin @(posedge clk_cpu); #1; cyc++; end
    chk(osc_stop == 1'b0, "R9", "osc_stop after exit", osc_stop, 0);
    cyc = 0;
    while (!cpu_clk_out && cyc < 100) begin @(posedge clk_cpu); #1; cyc++; end
    chk(cyc >= SETTLE && cyc <= SETTLE + 6, "R9", "cycles to restart", cyc, SETTLE + 3);
    #300;
    observe(4'hF, "R9");

    // R10: tristate override
    mon_on = 0;
    @(negedge clk_cpu); tristate_req = 1;
    #1;
    chk(pad_oe == 1'b0, "R10", "pad_oe in tristate", pad_oe, 0);
    observe(4'h0, "R10");
    @(negedge clk_cpu); tristate_req = 0;
    #100;
    mon_on = 1;
    chk(pad_oe == 1'b1, "R10", "pad_oe restored", pad_oe, 1);
    observe(4'hF, "R10");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule